// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block is a small, fully associative instruction cache for a 15-bit code address space. It sits between an instruction fetch unit and a slower flash line fetcher. It has thirty-two slots and one linear prefetch entry. Each slot holds a 4-byte line, a 13-bit tag, a valid bit and a lock bit. The linear prefetch entry holds the most recently filled line under its own tag and valid bit. Each fetch looks up all slots and the linear entry in the same cycle. On a hit, the addressed byte comes back with no stall.

On a miss, the block requests the line from flash and counts how many cycles the fetch unit stalls. When the line arrives, it is always loaded into the linear entry. It is written into a cache slot only when the stall exceeded a 2-bit programmable penalty threshold, so short misses do not pollute the cache. The victim slot is chosen by an external index. A victim slot that is locked is never overwritten. A flush command and a preload port let software clear the cache, and pre-load and pin time-critical lines.

The control is a two-state machine:
- `S_IDLE` accepts lookups.
- The transition `miss_detect` moves `S_IDLE` to `S_MISS` when a requested line is absent.
- `S_MISS` holds the flash request.
- The transition `fill_done` moves `S_MISS` back to `S_IDLE` on the cycle the flash acknowledge arrives.
- The transition `hit_stay` keeps the machine in `S_IDLE` on a hit or when no fetch is requested.
- The transition `wait_fill` keeps it in `S_MISS` while the acknowledge is absent.

Top module: `bt_icache`

## Requirements
- R1: After reset, the block holds the following state:
  - every slot and the linear entry are invalid, and every lock bit is clear;
  - the penalty threshold is 0;
  - the machine is in `S_IDLE` with `fl_req` low and `fetch_rdy` low;
  - the first fetch after reset misses.
- R2: When `fetch_req` is high in `S_IDLE` and bits 14:2 of `fetch_addr` match the tag of a valid slot, `fetch_rdy` is high in that same cycle. `fetch_byte` then carries byte `fetch_addr[1:0]` of the line, where byte k is line bits 8k+7:8k.
- R3: Every completed flash fill loads its tag and line into the linear entry, whatever the threshold. A later fetch whose tag matches the valid linear entry hits with no stall.
- R4: A miss works as follows:
  - On a miss, `fetch_rdy` is low in the lookup cycle.
  - From the next cycle, `fl_req` is high with `fl_tag` equal to the missed address bits 14:2, and stays high and stable until `fl_ack`.
  - In the `fl_ack` cycle, `fetch_rdy` is high and `fetch_byte` is the selected byte of `fl_line`.
- R5: The stall count of a miss is the number of cycles that `fetch_req` is high without `fetch_rdy`. It is 1 when `fl_ack` arrives in the first `S_MISS` cycle, and it saturates at 15.
- R6: When a fill completes with a stall count greater than the threshold, the line is written into slot `victim_idx`, sampled in the `fl_ack` cycle, and that slot becomes valid.
- R7: A `cfg_thr_we` pulse loads `cfg_thr` into the threshold. With a threshold of 2, misses stalling 1 or 2 cycles are not cached, and misses stalling 3 or more cycles are cached.
- R8: A locked victim slot is never overwritten by a fill. Its tag, line and valid bit are unchanged, and its old line still hits.
- R9: A `flush` pulse invalidates every unlocked slot and the linear entry in one cycle. Locked slots stay valid.
- R10: A `pl_we` pulse writes `pl_tag` and `pl_line` into slot `pl_slot`, sets its valid bit and sets its lock bit to `pl_lock`. This happens regardless of the threshold and in either state.
- R11: Writes in the same cycle follow a fixed priority:
  - a flush overrides a preload or fill;
  - a preload overrides a fill to the same slot.
- R12: When both a slot and the linear entry match, the slot's line is returned. Among matching slots, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request, held until `fetch_rdy` |
| fetch_addr | input | 15 | Code byte address |
| fetch_rdy | output | 1 | Byte valid this cycle |
| fetch_byte | output | 8 | Returned instruction byte |
| fl_req | output | 1 | Flash line request |
| fl_tag | output | 13 | Line address requested from flash |
| fl_ack | input | 1 | Flash line available this cycle |
| fl_line | input | 32 | Flash line data |
| victim_idx | input | 5 | Slot to replace on allocation |
| cfg_thr_we | input | 1 | Load penalty threshold |
| cfg_thr | input | 2 | New penalty threshold |
| flush | input | 1 | Invalidate unlocked slots and linear entry |
| pl_we | input | 1 | Preload strobe |
| pl_slot | input | 5 | Preload target slot |
| pl_tag | input | 13 | Preload tag |
| pl_line | input | 32 | Preload line |
| pl_lock | input | 1 | Lock value written by preload |

## Verification
The assertions assume that the fetch unit holds `fetch_req` and `fetch_addr` steady from the lookup cycle until `fetch_rdy`. They also assume that `fl_ack` only arrives while `fl_req` is high. The stimulus keeps to both rules: each fetch is driven by one task that raises the request, waits out the randomly chosen flash latency, and pulses the acknowledge only in the `S_MISS` state. The task then drops the request. Flush, preload and threshold writes are issued between fetches. The exceptions are two directed cases, which place a flush together with a preload, and a preload on the acknowledge cycle, to exercise the write priority.

// File: rtl/bt_icache_pkg.sv
package bt_icache_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_MISS = 1'b1
    } cache_state_e;
endpackage

// File: rtl/bt_miss_timer.sv
module bt_miss_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(1);
        end else if (run && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt = cnt_q;

    // R5
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

    // R5
    cnt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/bt_line_buf.sv
module bt_line_buf #(
    parameter int TAG_W  = 13,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              ld,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [LINE_W-1:0] ld_line,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [LINE_W-1:0] lk_line
);
    logic              valid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            line_q  <= '0;
        end else if (flush) begin
            valid_q <= 1'b0;
        end else if (ld) begin
            valid_q <= 1'b1;
            tag_q   <= ld_tag;
            line_q  <= ld_line;
        end
    end

    assign lk_hit  = valid_q && (tag_q == lk_tag);
    assign lk_line = line_q;

    // R9
    lin_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !valid_q);

    // R3
    lin_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !flush) |=> (valid_q && tag_q == $past(ld_tag) && line_q == $past(ld_line)));
endmodule

// File: rtl/bt_tag_store.sv
module bt_tag_store #(
    parameter int SLOTS  = 32,
    parameter int TAG_W  = 13,
    parameter int LINE_W = 32,
    parameter int IDX_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [LINE_W-1:0] lk_line,
    input  logic              flush,
    input  logic              pl_we,
    input  logic [IDX_W-1:0]  pl_idx,
    input  logic [TAG_W-1:0]  pl_tag,
    input  logic [LINE_W-1:0] pl_line,
    input  logic              pl_lock,
    input  logic              al_we,
    input  logic [IDX_W-1:0]  al_idx,
    input  logic [TAG_W-1:0]  al_tag,
    input  logic [LINE_W-1:0] al_line
);
    logic [SLOTS-1:0]  valid_q;
    logic [SLOTS-1:0]  lock_q;
    logic [SLOTS-1:0]  match;
    logic [TAG_W-1:0]  tag_q  [SLOTS];
    logic [LINE_W-1:0] line_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic pl_sel;
        logic al_sel;

        assign match[g] = valid_q[g] && (tag_q[g] == lk_tag);
        assign pl_sel   = pl_we && (pl_idx == IDX_W'(g));
        assign al_sel   = al_we && (al_idx == IDX_W'(g)) && !lock_q[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                lock_q[g]  <= 1'b0;
                tag_q[g]   <= '0;
                line_q[g]  <= '0;
            end else if (flush) begin
                if (!lock_q[g]) begin
                    valid_q[g] <= 1'b0;
                end
            end else if (pl_sel) begin
                valid_q[g] <= 1'b1;
                lock_q[g]  <= pl_lock;
                tag_q[g]   <= pl_tag;
                line_q[g]  <= pl_line;
            end else if (al_sel) begin
                valid_q[g] <= 1'b1;
                tag_q[g]   <= al_tag;
                line_q[g]  <= al_line;
            end
        end

        // R8
        lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_q[g] && !pl_sel) |=> ($stable(tag_q[g]) && $stable(line_q[g]) && valid_q[g] == $past(valid_q[g])));
    end

    always_comb begin
        lk_line = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_line = line_q[i];
            end
        end
    end

    assign lk_hit = |match;

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((valid_q & ~lock_q) == '0));

    // R10
    preload_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_we && !flush) |=> (valid_q[$past(pl_idx)] && lock_q[$past(pl_idx)] == $past(pl_lock)));
endmodule

// File: rtl/bt_icache.sv
module bt_icache
    import bt_icache_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int SLOTS      = 32,
    parameter int LINE_BYTES = 4,
    parameter int THR_W      = 2,
    parameter int CNT_W      = 4,
    parameter int OFS_W      = $clog2(LINE_BYTES),
    parameter int TAG_W      = ADDR_W - OFS_W,
    parameter int LINE_W     = 8 * LINE_BYTES,
    parameter int IDX_W      = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_rdy,
    output logic [7:0]        fetch_byte,
    output logic              fl_req,
    output logic [TAG_W-1:0]  fl_tag,
    input  logic              fl_ack,
    input  logic [LINE_W-1:0] fl_line,
    input  logic [IDX_W-1:0]  victim_idx,
    input  logic              cfg_thr_we,
    input  logic [THR_W-1:0]  cfg_thr,
    input  logic              flush,
    input  logic              pl_we,
    input  logic [IDX_W-1:0]  pl_slot,
    input  logic [TAG_W-1:0]  pl_tag,
    input  logic [LINE_W-1:0] pl_line,
    input  logic              pl_lock
);
    cache_state_e      state_q;
    cache_state_e      state_d;
    logic [ADDR_W-1:0] miss_addr_q;
    logic [THR_W-1:0]  thr_q;
    logic [TAG_W-1:0]  lk_tag;
    logic              slot_hit;
    logic [LINE_W-1:0] slot_line;
    logic              lin_hit;
    logic [LINE_W-1:0] lin_line;
    logic              any_hit;
    logic [LINE_W-1:0] hit_line;
    logic              miss_start;
    logic              fill_done;
    logic              alloc_ok;
    logic [CNT_W-1:0]  stall_cnt;
    logic [OFS_W-1:0]  hit_sel;
    logic [OFS_W-1:0]  miss_sel;

    assign lk_tag    = fetch_addr[ADDR_W-1:OFS_W];
    assign hit_sel   = fetch_addr[OFS_W-1:0];
    assign miss_sel  = miss_addr_q[OFS_W-1:0];
    assign any_hit   = slot_hit || lin_hit;
    assign hit_line  = slot_hit ? slot_line : lin_line;

    assign miss_start = (state_q == S_IDLE) && fetch_req && !any_hit;
    assign fill_done  = (state_q == S_MISS) && fl_ack;
    assign alloc_ok   = fill_done && (stall_cnt > CNT_W'(thr_q));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: hit_stay / miss_detect / wait_fill / fill_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (miss_start) state_d = S_MISS;
            S_MISS: if (fl_ack)     state_d = S_IDLE;
            default:                state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fetch_rdy  = 1'b0;
        fetch_byte = '0;
        fl_req     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                fetch_rdy  = fetch_req && any_hit;
                fetch_byte = hit_line[{hit_sel, 3'b000} +: 8];
            end
            S_MISS: begin
                fl_req     = 1'b1;
                fetch_rdy  = fl_ack;
                fetch_byte = fl_line[{miss_sel, 3'b000} +: 8];
            end
            default: ;
        endcase
    end

    assign fl_tag = miss_addr_q[ADDR_W-1:OFS_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss_addr_q <= '0;
        end else if (miss_start) begin
            miss_addr_q <= fetch_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (cfg_thr_we) begin
            thr_q <= cfg_thr;
        end
    end

    bt_miss_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (miss_start),
        .run   ((state_q == S_MISS) && !fl_ack),
        .cnt   (stall_cnt)
    );

    bt_tag_store #(
        .SLOTS  (SLOTS),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_tag  (lk_tag),
        .lk_hit  (slot_hit),
        .lk_line (slot_line),
        .flush   (flush),
        .pl_we   (pl_we),
        .pl_idx  (pl_slot),
        .pl_tag  (pl_tag),
        .pl_line (pl_line),
        .pl_lock (pl_lock),
        .al_we   (alloc_ok),
        .al_idx  (victim_idx),
        .al_tag  (fl_tag),
        .al_line (fl_line)
    );

    bt_line_buf #(
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_linear (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .ld      (fill_done),
        .ld_tag  (fl_tag),
        .ld_line (fl_line),
        .lk_tag  (lk_tag),
        .lk_hit  (lin_hit),
        .lk_line (lin_line)
    );

    // R4
    fl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_tag)));

    // R4
    miss_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_start |=> (fl_req && fl_tag == $past(fetch_addr[ADDR_W-1:OFS_W])));

    // R2
    rdy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rdy |-> fetch_req);

    // R7
    thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_thr_we |=> thr_q == $past(cfg_thr));
endmodule

// File: tb/bt_icache_bench.sv
`timescale 1ns/1ps
module bt_icache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [14:0] fetch_addr = '0;
    logic        fetch_rdy;
    logic [7:0]  fetch_byte;
    logic        fl_req;
    logic [12:0] fl_tag;
    logic        fl_ack = 1'b0;
    logic [31:0] fl_line = '0;
    logic [4:0]  victim_idx = '0;
    logic        cfg_thr_we = 1'b0;
    logic [1:0]  cfg_thr = '0;
    logic        flush = 1'b0;
    logic        pl_we = 1'b0;
    logic [4:0]  pl_slot = '0;
    logic [12:0] pl_tag = '0;
    logic [31:0] pl_line = '0;
    logic        pl_lock = 1'b0;

    always #2 clk = ~clk;

    bt_icache u_bt_icache (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_rdy(fetch_rdy), .fetch_byte(fetch_byte), .fl_req(fl_req), .fl_tag(fl_tag),
        .fl_ack(fl_ack), .fl_line(fl_line), .victim_idx(victim_idx),
        .cfg_thr_we(cfg_thr_we), .cfg_thr(cfg_thr), .flush(flush), .pl_we(pl_we),
        .pl_slot(pl_slot), .pl_tag(pl_tag), .pl_line(pl_line), .pl_lock(pl_lock)
    );

    // Reference model
    bit          m_valid [32];
    bit          m_lock  [32];
    logic [12:0] m_tag   [32];
    logic [31:0] m_line  [32];
    bit          m_lin_v;
    logic [12:0] m_lin_tag;
    logic [31:0] m_lin_line;
    int          m_thr;
    int          vectors = 0;
    int          misses  = 0;
    bit          done    = 1'b0;

    function automatic logic [31:0] flash_of(logic [12:0] t);
        return {t[7:0] ^ 8'hA5, t[12:5], t[7:0] + 8'h3C, ~t[7:0]};
    endfunction

    function automatic bit model_find(logic [12:0] t, output logic [31:0] ln);
        for (int i = 0; i < 32; i++) begin
            if (m_valid[i] && m_tag[i] == t) begin
                ln = m_line[i];
                return 1'b1;
            end
        end
        if (m_lin_v && m_lin_tag == t) begin
            ln = m_lin_line;
            return 1'b1;
        end
        ln = '0;
        return 1'b0;
    endfunction

    function automatic logic [7:0] byte_of(logic [31:0] ln, logic [1:0] s);
        return ln[s*8 +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_flush();
        for (int i = 0; i < 32; i++) if (!m_lock[i]) m_valid[i] = 1'b0;
        m_lin_v = 1'b0;
    endtask

    task automatic model_preload(int s, logic [12:0] t, logic [31:0] ln, bit lk);
        m_valid[s] = 1'b1; m_lock[s] = lk; m_tag[s] = t; m_line[s] = ln;
    endtask

    // One fetch; lat = S_MISS cycles without ack; optional preload to the victim on the ack cycle
    task automatic do_fetch(input logic [14:0] a, input int lat, input int v,
                            input bit pl_now, input logic [12:0] pt, input logic [31:0] pln, input bit plk);
        logic [31:0] ln;
        bit hit;
        int stall;
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a;
        #1;
        hit = model_find(a[14:2], ln);
        if (hit) begin
            chk(fetch_rdy == 1'b1, "R2/R3/R12 hit ready", {31'd0, fetch_rdy}, 32'd1);
            chk(fetch_byte == byte_of(ln, a[1:0]), "R2/R3/R12 hit byte", {24'd0, fetch_byte}, {24'd0, byte_of(ln, a[1:0])});
            @(posedge clk); #1;
            fetch_req = 1'b0;
        end else begin
            chk(fetch_rdy == 1'b0, "R4 miss not ready", {31'd0, fetch_rdy}, 32'd0);
            @(posedge clk);
            for (int k = 0; k < lat; k++) begin
                @(negedge clk); #1;
                chk(fl_req == 1'b1 && fl_tag == a[14:2], "R4 flash request", {18'd0, fl_req, fl_tag}, {18'd0, 1'b1, a[14:2]});
                chk(fetch_rdy == 1'b0, "R4 stalled", {31'd0, fetch_rdy}, 32'd0);
                @(posedge clk);
            end
            @(negedge clk);
            fl_ack = 1'b1; fl_line = flash_of(a[14:2]); victim_idx = 5'(v);
            if (pl_now) begin
                pl_we = 1'b1; pl_slot = 5'(v); pl_tag = pt; pl_line = pln; pl_lock = plk;
            end
            #1;
            chk(fetch_rdy == 1'b1, "R4 fill ready", {31'd0, fetch_rdy}, 32'd1);
            chk(fetch_byte == byte_of(flash_of(a[14:2]), a[1:0]), "R4 fill byte",
                {24'd0, fetch_byte}, {24'd0, byte_of(flash_of(a[14:2]), a[1:0])});
            @(posedge clk); #1;
            fl_ack = 1'b0; fetch_req = 1'b0; pl_we = 1'b0;
            stall = (lat + 1 > 15) ? 15 : lat + 1;
            m_lin_v = 1'b1; m_lin_tag = a[14:2]; m_lin_line = flash_of(a[14:2]);
            if (pl_now) model_preload(v, pt, pln, plk);
            else if (stall > m_thr && !m_lock[v]) begin
                m_valid[v] = 1'b1; m_tag[v] = a[14:2]; m_line[v] = flash_of(a[14:2]);
            end
        end
    endtask

    task automatic fetch(input logic [14:0] a, input int lat, input int v);
        do_fetch(a, lat, v, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic do_flush(input bit with_pl, input int s, input logic [12:0] t, input logic [31:0] ln);
        @(negedge clk);
        flush = 1'b1;
        if (with_pl) begin pl_we = 1'b1; pl_slot = 5'(s); pl_tag = t; pl_line = ln; pl_lock = 1'b1; end
        @(posedge clk); #1;
        flush = 1'b0; pl_we = 1'b0;
        model_flush();
    endtask

    task automatic do_preload(input int s, input logic [12:0] t, input logic [31:0] ln, input bit lk);
        @(negedge clk);
        pl_we = 1'b1; pl_slot = 5'(s); pl_tag = t; pl_line = ln; pl_lock = lk;
        @(posedge clk); #1;
        pl_we = 1'b0;
        model_preload(s, t, ln, lk);
    endtask

    task automatic set_thr(input int t);
        @(negedge clk);
        cfg_thr_we = 1'b1; cfg_thr = 2'(t);
        @(posedge clk); #1;
        cfg_thr_we = 1'b0;
        m_thr = t;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        for (int i = 0; i < 32; i++) begin m_valid[i] = 0; m_lock[i] = 0; m_tag[i] = '0; m_line[i] = '0; end
        m_lin_v = 0; m_lin_tag = '0; m_lin_line = '0; m_thr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        chk(fl_req == 1'b0, "R1 fl_req low", {31'd0, fl_req}, 32'd0);
        chk(fetch_rdy == 1'b0, "R1 rdy low", {31'd0, fetch_rdy}, 32'd0);
        // R1: first fetch misses; threshold 0 caches a 1-cycle stall (R6, R7)
        fetch(15'h0123, 0, 3);
        fetch(15'h0600, 1, 4);
        fetch(15'h0122, 0, 0);   // R6: hit from slot 3
        // R7: threshold 2
        set_thr(2);
        fetch(15'h1000, 0, 6);   // stall 1, not cached
        fetch(15'h1100, 1, 7);   // stall 2, not cached
        fetch(15'h1200, 2, 8);   // stall 3, cached
        fetch(15'h1300, 3, 9);   // stall 4, cached
        fetch(15'h1001, 0, 10);  // R7: miss again
        fetch(15'h1102, 0, 10);  // R7: miss again
        fetch(15'h1203, 0, 10);  // R7: hit in slot 8
        fetch(15'h1301, 0, 10);  // R7: hit in slot 9
        // R8: locked victim
        do_preload(5, 13'h0AAA, 32'hDEAD_BEEF, 1'b1);
        fetch(15'h2000, 6, 5);
        fetch(15'h2400, 0, 11);
        fetch({13'h0AAA, 2'd2}, 0, 0);
        // R12: slot over linear
        fetch(15'h3000, 0, 12);  // linear holds 0xC00
        do_preload(13, 13'h0C00, 32'h1122_3344, 1'b0);
        fetch(15'h3001, 0, 0);
        // R9: flush keeps locked slot
        do_flush(1'b0, 0, '0, '0);
        fetch({13'h0AAA, 2'd3}, 0, 0);
        fetch(15'h1200, 0, 14);
        // R11: flush beats preload
        do_flush(1'b1, 20, 13'h0777, 32'h5555_AAAA);
        fetch({13'h0777, 2'd1}, 0, 21);
        // R11: preload beats fill to same slot (R10 during S_MISS)
        set_thr(0);
        do_fetch(15'h3800, 3, 22, 1'b1, 13'h0999, 32'hCAFE_F00D, 1'b0);
        fetch({13'h0999, 2'd0}, 0, 0);
        fetch(15'h3800, 0, 0);
        // Constrained random mix
        for (int n = 0; n < 1500; n++) begin
            int op;
            op = $urandom % 100;
            if (op < 75) begin
                fetch({13'(100 + $urandom % 24), 2'($urandom)}, $urandom % 17, $urandom % 32);
            end else if (op < 87) begin
                do_preload($urandom % 32, 13'(100 + $urandom % 24), $urandom, ($urandom % 4) == 0);
            end else if (op < 91) begin
                do_flush(1'b0, 0, '0, '0);
            end else begin
                set_thr($urandom % 4);
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule